// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block takes 8- or 9-bit words from a four-entry transmit queue and sends them out on one serial line as NRZ frames. The frame layout is chosen while running: a 2-bit format field selects data width and parity, and a 1-bit field selects one or two stop bits. A programmable divider sets the bit rate. The divider produces a 16x oversampling tick that a companion receiver can share.

Two enables gate the transmitter. The module enable is the master switch. Dropping it stops any frame partway through, empties the queue, clears the divider and forces the status outputs to their idle values. The transmit enable only decides whether a queued word may begin a new frame. A break request holds the line low. The status outputs report a full queue, an idle shifter, the latched transmit enable and the latched break state.

Top module: `frame_tx`

## Requirements
- R1: After reset, and whenever no frame or break is active, `txLine` is 1. Reset leaves `shiftEmpty`=1 and `bufFull`, `txEnFlag`, `brkFlag` at 0.
- R2: A frame is one start bit (0), then the data bits least significant first, then any parity bit, then the stop bits (1). Each bit lasts (divisor+1)×16 clock cycles.
- R3: `fmtSel` selects the format: 00 means 8 data bits with no parity, 01 means 8 bits with even parity, 10 means 8 bits with odd parity, and 11 means 9 data bits with no parity.
- R4: Even parity makes the number of ones in the data plus parity even. Odd parity makes that number odd. The parity bit follows the last data bit.
- R5: `stopSel`=0 sends one stop bit and `stopSel`=1 sends two. A queued word starts its frame in the bit period right after the last stop bit.
- R6: The queue holds 4 words. `bufFull` is 1 exactly when 4 words are stored. A write while the queue is full is dropped, even in the cycle in which a frame start removes a word.
- R7: A frame starts only when the latched transmit enable is 1 and the queue is not empty. While `txEnReq` is 0, queued words stay queued and the line stays at 1.
- R8: Clearing `modEn` aborts the frame in flight. The clock edge that samples `modEn`=0 sets the line back to 1, empties the queue, clears the divider, forces `txEnFlag`, `brkFlag` and `bufFull` to 0, and sets `shiftEmpty` to 1. After re-enabling, words sent earlier are not transmitted, and new frames use the configuration present on the ports.
- R9: While the module is enabled, `brkReq` is latched into `brkFlag` one cycle later, and `brkFlag`=1 holds `txLine` at 0. While the module is disabled, `brkFlag` stays 0.
- R10: A write presented while `modEn` is 0 is ignored: no frame results after re-enabling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modEn | input | 1 | Module enable; 0 aborts and clears |
| txEnReq | input | 1 | Transmit enable request |
| brkReq | input | 1 | Break request (line held low) |
| fmtSel | input | 2 | Data width and parity select |
| stopSel | input | 1 | 0: one stop bit, 1: two stop bits |
| divisor | input | DIV_W | Bit period is (divisor+1)×16 clocks |
| wrValid | input | 1 | Write strobe for the transmit queue |
| wrData | input | 9 | Word to enqueue (bit 8 used in 9-bit format) |
| txLine | output | 1 | Serial output, idles at 1 |
| bufFull | output | 1 | Queue holds 4 words |
| shiftEmpty | output | 1 | No frame in progress |
| txEnFlag | output | 1 | Latched transmit enable |
| brkFlag | output | 1 | Latched break state |

## Verification
A write to a full queue can land in the same cycle in which a frame start takes the head word out of that queue. The bench fills the queue with transmit enable low, then raises the enable and presents a fifth write timed for the clock edge that starts the first frame. The result is judged at the ports: `bufFull` must drop to 0 right after that edge, exactly the four original words must come out in order, and the line must stay idle afterwards, which shows the colliding write was dropped.

// File: rtl/frame_tx_pkg.sv
`timescale 1ns/1ps
package frame_tx_pkg;
  localparam int WORD_W = 9;

  localparam logic [1:0] FMT_8N = 2'b00;
  localparam logic [1:0] FMT_8E = 2'b01;
  localparam logic [1:0] FMT_8O = 2'b10;
  localparam logic [1:0] FMT_9N = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } frameState_t;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA,
    LINE_PAR
  } lineSel_t;

  typedef struct packed {
    logic     load;
    logic     shift;
    logic     flush;
    lineSel_t lineSel;
  } dpStrobe_t;
endpackage

// File: rtl/frame_tx_ctrl.sv
`timescale 1ns/1ps
module frame_tx_ctrl
  import frame_tx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modEn,
  input  logic             txEnReq,
  input  logic             brkReq,
  input  logic [1:0]       fmtSel,
  input  logic             stopSel,
  input  logic [DIV_W-1:0] divisor,
  input  logic             fifoEmpty,
  output dpStrobe_t        strb,
  output logic             shiftEmpty,
  output logic             txEnFlag,
  output logic             brkFlag
);
  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

  frameState_t      state, stNext;
  logic [DIV_W-1:0] preCnt;
  logic [SUB_W-1:0] subCnt;
  logic [3:0]       bitIdx;
  logic             stopIdx;
  logic             tick16, bitDone, canStart, hasPar;
  logic [3:0]       dataLast;

  assign tick16   = (preCnt >= divisor);
  assign bitDone  = tick16 && (subCnt == SUB_LAST);
  assign canStart = txEnFlag && !fifoEmpty;
  assign hasPar   = (fmtSel == FMT_8E) || (fmtSel == FMT_8O);
  assign dataLast = (fmtSel == FMT_9N) ? 4'd8 : 4'd7;

  always_comb begin
    stNext       = state;
    strb.load    = 1'b0;
    strb.shift   = 1'b0;
    strb.flush   = !modEn;
    strb.lineSel = LINE_MARK;
    unique case (state)
      ST_IDLE: begin
        if (tick16 && canStart) begin
          strb.load = 1'b1;
          stNext    = ST_START;
        end
      end
      ST_START: begin
        strb.lineSel = LINE_SPACE;
        if (bitDone) stNext = ST_DATA;
      end
      ST_DATA: begin
        strb.lineSel = LINE_DATA;
        if (bitDone) begin
          strb.shift = 1'b1;
          if (bitIdx == dataLast) stNext = hasPar ? ST_PAR : ST_STOP;
        end
      end
      ST_PAR: begin
        strb.lineSel = LINE_PAR;
        if (bitDone) stNext = ST_STOP;
      end
      ST_STOP: begin
        if (bitDone && (stopIdx == stopSel)) begin
          if (canStart) begin
            strb.load = 1'b1;
            stNext    = ST_START;
          end else begin
            stNext = ST_IDLE;
          end
        end
      end
      default: stNext = ST_IDLE;
    endcase
    if (!modEn) begin
      strb.load = 1'b0;
      stNext    = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      preCnt   <= '0;
      subCnt   <= '0;
      bitIdx   <= '0;
      stopIdx  <= 1'b0;
      txEnFlag <= 1'b0;
      brkFlag  <= 1'b0;
    end else if (!modEn) begin
      state    <= ST_IDLE;
      preCnt   <= '0;
      subCnt   <= '0;
      bitIdx   <= '0;
      stopIdx  <= 1'b0;
      txEnFlag <= 1'b0;
      brkFlag  <= 1'b0;
    end else begin
      state    <= stNext;
      txEnFlag <= txEnReq;
      brkFlag  <= brkReq;
      preCnt   <= tick16 ? '0 : preCnt + 1'b1;
      if (strb.load) subCnt <= '0;
      else if (tick16 && state != ST_IDLE) subCnt <= bitDone ? '0 : subCnt + 1'b1;
      if (strb.load) bitIdx <= '0;
      else if (state == ST_DATA && bitDone) bitIdx <= bitIdx + 4'd1;
      if (state != ST_STOP) stopIdx <= 1'b0;
      else if (bitDone) stopIdx <= !stopIdx;
    end
  end

  assign shiftEmpty = (state == ST_IDLE);

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |=> (shiftEmpty && !txEnFlag && !brkFlag))
    else $error("disable did not return control to idle"); // R8

  AST_START_GATE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (txEnFlag && !fifoEmpty && modEn))
    else $error("frame started without enable or data"); // R7
endmodule

// File: rtl/frame_tx_dp.sv
`timescale 1ns/1ps
module frame_tx_dp
  import frame_tx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modEn,
  input  dpStrobe_t         strb,
  input  logic [1:0]        fmtSel,
  input  logic              wrValid,
  input  logic [WORD_W-1:0] wrData,
  input  logic              brkFlag,
  output logic              fifoEmpty,
  output logic              bufFull,
  output logic              txLine
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [WORD_W-1:0] fifoMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fifoCnt;
  logic [WORD_W-1:0] shiftReg, headWord;
  logic              parBit, wrAccept, pop;

  assign bufFull   = (fifoCnt == CNT_FULL);
  assign fifoEmpty = (fifoCnt == '0);
  assign wrAccept  = modEn && wrValid && !bufFull;
  assign pop       = strb.load;
  assign headWord  = fifoMem[rdPtr];

  always_ff @(posedge clk) begin
    if (wrAccept) fifoMem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fifoCnt <= '0;
    end else if (strb.flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fifoCnt <= '0;
    end else begin
      if (wrAccept) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (pop)      rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      unique case ({wrAccept, pop})
        2'b10:   fifoCnt <= fifoCnt + 1'b1;
        2'b01:   fifoCnt <= fifoCnt - 1'b1;
        default: fifoCnt <= fifoCnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (pop) begin
      shiftReg <= headWord;
      parBit   <= (fmtSel == FMT_8O) ^ (^headWord[7:0]);
    end else if (strb.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    unique case (strb.lineSel)
      LINE_SPACE: txLine = 1'b0;
      LINE_DATA:  txLine = shiftReg[0];
      LINE_PAR:   txLine = parBit;
      default:    txLine = 1'b1;
    endcase
    if (brkFlag) txLine = 1'b0;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !pop && modEn) |=> bufFull)
    else $error("full queue changed without a pop"); // R6

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    fifoCnt <= CNT_FULL)
    else $error("queue count out of range"); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |=> (fifoEmpty && !bufFull))
    else $error("queue not emptied on disable"); // R8
endmodule

// File: rtl/frame_tx.sv
`timescale 1ns/1ps
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modEn,
  input  logic              txEnReq,
  input  logic              brkReq,
  input  logic [1:0]        fmtSel,
  input  logic              stopSel,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              wrValid,
  input  logic [WORD_W-1:0] wrData,
  output logic              txLine,
  output logic              bufFull,
  output logic              shiftEmpty,
  output logic              txEnFlag,
  output logic              brkFlag
);
  dpStrobe_t strb;
  logic      fifoEmpty;

  frame_tx_ctrl #(.DIV_W(DIV_W), .OVERSAMPLE(16)) uCtrl (
    .clk(clk), .rstN(rstN), .modEn(modEn), .txEnReq(txEnReq), .brkReq(brkReq),
    .fmtSel(fmtSel), .stopSel(stopSel), .divisor(divisor), .fifoEmpty(fifoEmpty),
    .strb(strb), .shiftEmpty(shiftEmpty), .txEnFlag(txEnFlag), .brkFlag(brkFlag)
  );

  frame_tx_dp #(.DEPTH(FIFO_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .modEn(modEn), .strb(strb), .fmtSel(fmtSel),
    .wrValid(wrValid), .wrData(wrData), .brkFlag(brkFlag),
    .fifoEmpty(fifoEmpty), .bufFull(bufFull), .txLine(txLine)
  );

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEmpty && !brkFlag) |-> txLine)
    else $error("line not at mark while idle"); // R1
endmodule

// File: tb/frame_tx_test.sv
`timescale 1ns/1ps
module frame_tx_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modEn = 1'b0, txEnReq = 1'b0, brkReq = 1'b0, stopSel = 1'b0;
  logic [1:0]  fmtSel = 2'b00;
  logic [15:0] divisor = 16'd0;
  logic        wrValid = 1'b0;
  logic [8:0]  wrData = '0;
  logic        txLine, bufFull, shiftEmpty, txEnFlag, brkFlag;
  int          checks = 0, fails = 0;
  bit          finished = 1'b0;

  frame_tx uut (
    .clk(clk), .rstN(rstN), .modEn(modEn), .txEnReq(txEnReq), .brkReq(brkReq),
    .fmtSel(fmtSel), .stopSel(stopSel), .divisor(divisor), .wrValid(wrValid),
    .wrData(wrData), .txLine(txLine), .bufFull(bufFull), .shiftEmpty(shiftEmpty),
    .txEnFlag(txEnFlag), .brkFlag(brkFlag)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pushWord(input logic [8:0] w);
    @(negedge clk); wrValid = 1'b1; wrData = w;
    @(negedge clk); wrValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (shiftEmpty !== 1'b1) @(negedge clk);
  endtask

  task automatic quietFor(input int n, input string req, input string what);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txLine !== 1'b1 || shiftEmpty !== 1'b1) lows++;
    end
    chk(lows == 0, req, what, lows, 0);
  endtask

  // parMode: 0 none, 1 even, 2 odd; afterExp < 0 skips the look past the stops
  task automatic recvFrame(input int bitClks, input int nData, input int parMode, input int nStop,
                           input logic [8:0] exp, input int afterExp, input string req);
    logic [8:0] got = '0;
    int ones, parExp;
    while (txLine !== 1'b0) @(negedge clk);
    repeat (bitClks / 2) @(negedge clk);
    chk(txLine == 1'b0, req, "start bit", txLine, 0);
    for (int i = 0; i < nData; i++) begin
      repeat (bitClks) @(negedge clk);
      got[i] = txLine;
    end
    chk(got == exp, req, "data bits", got, exp);
    if (parMode != 0) begin
      ones   = $countones(exp[7:0]);
      parExp = (parMode == 1) ? (ones % 2) : (1 - ones % 2);
      repeat (bitClks) @(negedge clk);
      chk(txLine == parExp[0], req, "parity bit", txLine, parExp);
    end
    for (int s = 0; s < nStop; s++) begin
      repeat (bitClks) @(negedge clk);
      chk(txLine == 1'b1, req, "stop bit", txLine, 1);
    end
    if (afterExp >= 0) begin
      repeat (bitClks) @(negedge clk);
      chk(txLine == afterExp[0], req, "bit after stops", txLine, afterExp);
    end
  endtask

  task automatic testReset();
    chk(txLine == 1'b1, "R1", "reset line", txLine, 1);
    chk(shiftEmpty == 1'b1, "R1", "reset shiftEmpty", shiftEmpty, 1);
    chk(bufFull == 1'b0, "R1", "reset bufFull", bufFull, 0);
    chk(txEnFlag == 1'b0 && brkFlag == 1'b0, "R1", "reset flags", {txEnFlag, brkFlag}, 0);
  endtask

  task automatic testBasic();
    fmtSel = 2'b00; stopSel = 1'b0;
    pushWord(9'h0A5);
    recvFrame(16, 8, 0, 1, 9'h0A5, -1, "R2");
    waitIdle();
    pushWord(9'h03C);
    recvFrame(16, 8, 0, 1, 9'h03C, -1, "R3");
    waitIdle();
  endtask

  task automatic testPeriod();
    int n = 0;
    divisor = 16'd2;
    pushWord(9'h001);
    while (txLine !== 1'b0) @(negedge clk);
    while (txLine === 1'b0) begin n++; @(negedge clk); end
    chk(n == 48, "R2", "start bit length at divisor 2", n, 48);
    waitIdle();
    divisor = 16'd0;
  endtask

  task automatic testParity();
    stopSel = 1'b0;
    fmtSel = 2'b01; pushWord(9'h007);
    recvFrame(16, 8, 1, 1, 9'h007, -1, "R4");
    waitIdle();
    pushWord(9'h003);
    recvFrame(16, 8, 1, 1, 9'h003, -1, "R4");
    waitIdle();
    fmtSel = 2'b10; pushWord(9'h007);
    recvFrame(16, 8, 2, 1, 9'h007, -1, "R4");
    waitIdle();
    fmtSel = 2'b11; pushWord(9'h1A5);
    recvFrame(16, 9, 0, 1, 9'h1A5, -1, "R3");
    waitIdle();
    fmtSel = 2'b00;
  endtask

  task automatic testStops();
    for (int s = 0; s < 2; s++) begin
      stopSel = s[0];
      txEnReq = 1'b0;
      @(negedge clk);
      pushWord(9'h0F0); pushWord(9'h00F);
      txEnReq = 1'b1;
      recvFrame(16, 8, 0, s + 1, 9'h0F0, 0, "R5");
      waitIdle();
    end
    stopSel = 1'b0;
  endtask

  task automatic testFifo();
    txEnReq = 1'b0;
    @(negedge clk);
    pushWord(9'h011); pushWord(9'h022); pushWord(9'h033);
    chk(bufFull == 1'b0, "R6", "bufFull with 3", bufFull, 0);
    pushWord(9'h044);
    chk(bufFull == 1'b1, "R6", "bufFull with 4", bufFull, 1);
    pushWord(9'h055);
    chk(bufFull == 1'b1, "R6", "bufFull after dropped write", bufFull, 1);
    quietFor(100, "R7", "line busy while transmit disabled");
    txEnReq = 1'b1;
    @(negedge clk);
    wrValid = 1'b1; wrData = 9'h066;
    @(negedge clk);
    wrValid = 1'b0;
    chk(bufFull == 1'b0, "R6", "bufFull after pop colliding with write", bufFull, 0);
    recvFrame(16, 8, 0, 1, 9'h011, -1, "R6");
    recvFrame(16, 8, 0, 1, 9'h022, -1, "R6");
    recvFrame(16, 8, 0, 1, 9'h033, -1, "R6");
    recvFrame(16, 8, 0, 1, 9'h044, -1, "R6");
    waitIdle();
    quietFor(300, "R6", "frames from dropped writes");
  endtask

  task automatic testDisable();
    pushWord(9'h000); pushWord(9'h055); pushWord(9'h066);
    while (txLine !== 1'b0) @(negedge clk);
    repeat (40) @(negedge clk);
    modEn = 1'b0;
    @(negedge clk);
    chk(txLine == 1'b1, "R8", "line after abort", txLine, 1);
    chk(shiftEmpty == 1'b1, "R8", "shiftEmpty after abort", shiftEmpty, 1);
    chk(bufFull == 1'b0 && txEnFlag == 1'b0 && brkFlag == 1'b0, "R8", "flags after abort",
        {bufFull, txEnFlag, brkFlag}, 0);
    modEn = 1'b1;
    quietFor(300, "R8", "queued words survived disable");
    fmtSel = 2'b01;
    pushWord(9'h03D);
    recvFrame(16, 8, 1, 1, 9'h03D, -1, "R8");
    waitIdle();
    fmtSel = 2'b00;
  endtask

  task automatic testDisabledWrite();
    modEn = 1'b0;
    pushWord(9'h077);
    @(negedge clk);
    modEn = 1'b1;
    quietFor(300, "R10", "write while disabled");
  endtask

  task automatic testBreak();
    @(negedge clk); brkReq = 1'b1;
    @(negedge clk);
    chk(brkFlag == 1'b1, "R9", "brkFlag set", brkFlag, 1);
    chk(txLine == 1'b0, "R9", "line held low in break", txLine, 0);
    brkReq = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(txLine == 1'b1 && brkFlag == 1'b0, "R9", "break released", txLine, 1);
    modEn = 1'b0; brkReq = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(brkFlag == 1'b0 && txLine == 1'b1, "R9", "break while disabled", brkFlag, 0);
    brkReq = 1'b0; modEn = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    modEn = 1'b1; txEnReq = 1'b1;
    @(negedge clk);
    testBasic();
    testPeriod();
    testParity();
    testStops();
    testFifo();
    testDisable();
    testDisabledWrite();
    testBreak();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule